// File: doc/BRIEF.md
# DDR PHY Read-Window Termination Controller

This block holds the PHY control word for a DDR data path and turns it into the on-die-termination (ODT) code, the write-ODT code, the input-receiver power-down signal and the PHY reset hold. Software writes the control word through a simple write/read port. A write only lands in a shadow copy. The shadow is moved into the active copy, the one that drives the outputs, when a later write to the memory-configuration register raises an update request and the PHY side answers with a one-cycle acknowledge.

The block also tracks the read-in-progress window. A read-command pulse opens the window, or extends it if one is already open. The window stays open for the programmed read latency plus the burst length. While the window is open, the receivers are powered and the read-ODT code is driven, unless the data output enable is high. Outside the window, with dynamic power-down on, the receivers are powered down and the idle-ODT code is driven.

The active word has these fields. Bit 20 is dynamic power-down enable. Bit 15 is PHY reset hold. Bits 13:12 are idle ODT, bits 11:10 are write ODT and bits 9:8 are read ODT. Bits LAT_W-1:0 hold the read latency, written as the total latency minus one. All other bits read as zero.

Top module: `ddr_term_ctrl`

## Requirements
- R1: After reset, both the shadow and the active word equal 0x0010_0000, and phy_rd_data returns the shadow word.
- R2: A phy_wr_en write changes only the shadow word, which phy_rd_data shows on the following cycle. No output changes until an update completes.
- R3: A mcfg_wr_en pulse sets upd_req on the next cycle. upd_req stays high until a cycle with upd_ack high. In that cycle the shadow is copied into the active word, and upd_req is low on the next cycle.
- R4: An upd_ack while upd_req is low is ignored, and the active word keeps its value.
- R5: A read command opens a window that covers the command cycle and the following (latency field + burst_len) cycles, where the latency field holds total latency minus one. The window is therefore latency field + 1 + burst_len cycles long in total.
- R6: A read command arriving while the window is open extends the window to whichever of the old and new windows ends later.
- R7: When bit 20 of the active word is 1, rx_pwrdn is high except while the read window is open. When bit 20 is 0, rx_pwrdn is always low.
- R8: While the read window is open, local_odt equals active bits 9:8 if dq_oe is low, and 00 if dq_oe is high. Codes: 00 and 01 mean off, 10 means full load, 11 means half load.
- R9: Outside the read window, local_odt equals active bits 13:12 when bit 20 is 1, and 00 when bit 20 is 0.
- R10: wr_local_odt equals active bits 11:10. phy_hold_rst equals active bit 15, where 1 holds the PHY in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_wr_en | input | 1 | Write strobe for the shadow control word |
| phy_wr_data | input | 32 | Control word write data |
| phy_rd_data | output | 32 | Shadow control word readback |
| mcfg_wr_en | input | 1 | Memory-configuration write pulse; starts an update |
| upd_req | output | 1 | Update request to the PHY |
| upd_ack | input | 1 | One-cycle update acknowledge |
| rd_cmd | input | 1 | Read-command pulse |
| burst_len | input | BL_W | Burst length in cycles, sampled with rd_cmd |
| dq_oe | input | 1 | Data output enable |
| local_odt | output | 2 | ODT code to the data macros |
| wr_local_odt | output | 2 | Write-ODT code to the data macros |
| rx_pwrdn | output | 1 | Input receiver power-down |
| phy_hold_rst | output | 1 | PHY reset hold, active high |

## Verification
Single reads are issued with two different latency and burst pairs, and the bench counts the cycles in which the receivers are powered. This shows whether the latency term and the burst term are both added, and whether the extra command-cycle term is included. A second command inside an open window shows whether an open window is extended or restarted. Reads with dq_oe high and low, repeated with dynamic power-down on and off, separate the read-ODT, idle-ODT and zero choices. Writes that are never committed, or that meet an acknowledge with no pending request, show that nothing reaches the outputs early.

// File: rtl/ddr_term_pkg.sv
package ddr_term_pkg;

   localparam int WORD_W     = 32;
   localparam int DYN_BIT    = 20;
   localparam int HOLD_BIT   = 15;
   localparam int IDLE_LSB   = 12;
   localparam int WODT_LSB   = 10;
   localparam int RODT_LSB   = 8;
   localparam int LAT_MAX_W  = 5;

   typedef struct packed {
      logic                 dyn;
      logic                 hold_rst;
      logic [1:0]           idle_odt;
      logic [1:0]           wr_odt;
      logic [1:0]           rd_odt;
      logic [LAT_MAX_W-1:0] lat;
   } term_cfg_t;

   localparam term_cfg_t CFG_RESET = '{dyn: 1'b1, default: '0};

   function automatic term_cfg_t cfg_unpack(input logic [WORD_W-1:0] w);
      term_cfg_t c;
      c.dyn      = w[DYN_BIT];
      c.hold_rst = w[HOLD_BIT];
      c.idle_odt = w[IDLE_LSB +: 2];
      c.wr_odt   = w[WODT_LSB +: 2];
      c.rd_odt   = w[RODT_LSB +: 2];
      c.lat      = w[LAT_MAX_W-1:0];
      return c;
   endfunction

   function automatic logic [WORD_W-1:0] cfg_pack(input term_cfg_t c);
      logic [WORD_W-1:0] w;
      w                    = '0;
      w[DYN_BIT]           = c.dyn;
      w[HOLD_BIT]          = c.hold_rst;
      w[IDLE_LSB +: 2]     = c.idle_odt;
      w[WODT_LSB +: 2]     = c.wr_odt;
      w[RODT_LSB +: 2]     = c.rd_odt;
      w[LAT_MAX_W-1:0]     = c.lat;
      return w;
   endfunction

endpackage

// File: rtl/term_cfg_regs.sv
module term_cfg_regs
   import ddr_term_pkg::*;
#(
   parameter int LAT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              cfg_wr,
   input  logic              upd_ack,
   output logic [WORD_W-1:0] rd_data,
   output logic              upd_req,
   output term_cfg_t         active
);

   localparam logic [LAT_MAX_W-1:0] LAT_MASK = LAT_MAX_W'((1 << LAT_W) - 1);

   term_cfg_t shadow_q;
   term_cfg_t wr_cfg;
   logic      commit;

   always_comb begin
      wr_cfg     = cfg_unpack(wr_data);
      wr_cfg.lat = wr_cfg.lat & LAT_MASK;
   end

   assign commit = upd_req & upd_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= CFG_RESET;
      end else if (wr_en) begin
         shadow_q <= wr_cfg;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_req <= 1'b0;
      end else if (cfg_wr) begin
         upd_req <= 1'b1;
      end else if (commit) begin
         upd_req <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= CFG_RESET;
      end else if (commit) begin
         active <= shadow_q;
      end
   end

   assign rd_data = cfg_pack(shadow_q);

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req && !upd_ack |=> upd_req);

   // R3
   commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_req && upd_ack |=> active == $past(shadow_q));

   // R4
   stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_req |=> $stable(active));

endmodule

// File: rtl/term_rd_window.sv
module term_rd_window #(
   parameter int LAT_W = 5,
   parameter int BL_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] lat,
   input  logic             rd_cmd,
   input  logic [BL_W-1:0]  burst_len,
   output logic             rd_active
);

   localparam int CNT_W = ((LAT_W > BL_W) ? LAT_W : BL_W) + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] dec;
   logic [CNT_W-1:0] load;

   assign dec  = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
   assign load = CNT_W'(lat) + CNT_W'(burst_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (rd_cmd) begin
         cnt_q <= (load > dec) ? load : dec;
      end else begin
         cnt_q <= dec;
      end
   end

   assign rd_active = rd_cmd | (cnt_q != '0);

   // R5
   win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_cmd && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);

   // R6
   win_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd && cnt_q > 1 |=> cnt_q >= $past(cnt_q) - 1'b1);

   // R5
   win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |-> rd_active);

endmodule

// File: rtl/term_odt_mux.sv
module term_odt_mux
   import ddr_term_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  term_cfg_t  cfg,
   input  logic       rd_active,
   input  logic       dq_oe,
   output logic [1:0] local_odt,
   output logic [1:0] wr_local_odt,
   output logic       rx_pwrdn,
   output logic       phy_hold_rst
);

   logic [1:0] odt_d;
   logic       pwrdn_d;

   always_comb begin
      if (rd_active) begin
         odt_d = dq_oe ? 2'b00 : cfg.rd_odt;
      end else if (cfg.dyn) begin
         odt_d = cfg.idle_odt;
      end else begin
         odt_d = 2'b00;
      end
      pwrdn_d = cfg.dyn & ~rd_active;
   end

   assign wr_local_odt = cfg.wr_odt;
   assign phy_hold_rst = cfg.hold_rst;

   generate
      if (OUT_REG) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               local_odt <= 2'b00;
               rx_pwrdn  <= CFG_RESET.dyn;
            end else begin
               local_odt <= odt_d;
               rx_pwrdn  <= pwrdn_d;
            end
         end
      end else begin : g_comb
         assign local_odt = odt_d;
         assign rx_pwrdn  = pwrdn_d;

         // R7
         pwrdn_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg.dyn |-> !rx_pwrdn);

         // R9
         idle_odt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_pwrdn |-> local_odt == cfg.idle_odt);

         // R8
         drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_active && dq_oe |-> local_odt == 2'b00);
      end
   endgenerate

endmodule

// File: rtl/ddr_term_ctrl.sv
module ddr_term_ctrl
   import ddr_term_pkg::*;
#(
   parameter int LAT_W   = 5,
   parameter int BL_W    = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phy_wr_en,
   input  logic [WORD_W-1:0] phy_wr_data,
   output logic [WORD_W-1:0] phy_rd_data,
   input  logic              mcfg_wr_en,
   output logic              upd_req,
   input  logic              upd_ack,
   input  logic              rd_cmd,
   input  logic [BL_W-1:0]   burst_len,
   input  logic              dq_oe,
   output logic [1:0]        local_odt,
   output logic [1:0]        wr_local_odt,
   output logic              rx_pwrdn,
   output logic              phy_hold_rst
);

   generate
      if (LAT_W < 1 || LAT_W > LAT_MAX_W) begin : g_bad_lat
         $error("LAT_W must be 1..5");
      end
      if (BL_W < 1 || BL_W > 8) begin : g_bad_bl
         $error("BL_W must be 1..8");
      end
   endgenerate

   term_cfg_t active;
   logic      rd_active;

   term_cfg_regs #(.LAT_W(LAT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (phy_wr_en),
      .wr_data (phy_wr_data),
      .cfg_wr  (mcfg_wr_en),
      .upd_ack (upd_ack),
      .rd_data (phy_rd_data),
      .upd_req (upd_req),
      .active  (active)
   );

   term_rd_window #(.LAT_W(LAT_W), .BL_W(BL_W)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .lat       (active.lat[LAT_W-1:0]),
      .rd_cmd    (rd_cmd),
      .burst_len (burst_len),
      .rd_active (rd_active)
   );

   term_odt_mux #(.OUT_REG(OUT_REG)) u_mux (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg          (active),
      .rd_active    (rd_active),
      .dq_oe        (dq_oe),
      .local_odt    (local_odt),
      .wr_local_odt (wr_local_odt),
      .rx_pwrdn     (rx_pwrdn),
      .phy_hold_rst (phy_hold_rst)
   );

   // R10
   hold_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_req |=> $stable(phy_hold_rst));

endmodule

// File: tb/ddr_term_ctrl_bench.sv
module ddr_term_ctrl_bench;

   localparam int BL_W = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            phy_wr_en = 1'b0;
   logic [31:0]     phy_wr_data = '0;
   logic [31:0]     phy_rd_data;
   logic            mcfg_wr_en = 1'b0;
   logic            upd_req;
   logic            upd_ack = 1'b0;
   logic            rd_cmd = 1'b0;
   logic [BL_W-1:0] burst_len = '0;
   logic            dq_oe = 1'b0;
   logic [1:0]      local_odt;
   logic [1:0]      wr_local_odt;
   logic            rx_pwrdn;
   logic            phy_hold_rst;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   ddr_term_ctrl #(.BL_W(BL_W)) u_ddr_term_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .phy_wr_en    (phy_wr_en),
      .phy_wr_data  (phy_wr_data),
      .phy_rd_data  (phy_rd_data),
      .mcfg_wr_en   (mcfg_wr_en),
      .upd_req      (upd_req),
      .upd_ack      (upd_ack),
      .rd_cmd       (rd_cmd),
      .burst_len    (burst_len),
      .dq_oe        (dq_oe),
      .local_odt    (local_odt),
      .wr_local_odt (wr_local_odt),
      .rx_pwrdn     (rx_pwrdn),
      .phy_hold_rst (phy_hold_rst)
   );

   function automatic logic [31:0] mk(input bit dyn, input bit hold,
                                      input logic [1:0] idle, input logic [1:0] wr,
                                      input logic [1:0] rd, input logic [4:0] lat);
      logic [31:0] w;
      w = '0;
      w[20] = dyn; w[15] = hold; w[13:12] = idle; w[11:10] = wr; w[9:8] = rd; w[4:0] = lat;
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // drive at negedge, sample 5 ns later
   task automatic wr_shadow(input logic [31:0] d);
      @(negedge clk); phy_wr_en = 1'b1; phy_wr_data = d;
      @(negedge clk); phy_wr_en = 1'b0;
   endtask

   task automatic commit();
      @(negedge clk); mcfg_wr_en = 1'b1;
      @(negedge clk); mcfg_wr_en = 1'b0; upd_ack = 1'b1;
      @(negedge clk); upd_ack = 1'b0;
   endtask

   task automatic count_window(input int gap, input logic [BL_W-1:0] bl,
                               input logic [BL_W-1:0] bl2, output int n);
      n = 0;
      for (int i = 0; i < 80; i++) begin
         @(negedge clk);
         rd_cmd    = (i == 0) || (gap > 0 && i == gap);
         burst_len = (i == 0) ? bl : bl2;
         #5;
         if (!rx_pwrdn) n++;
      end
      @(negedge clk); rd_cmd = 1'b0;
   endtask

   task automatic t_reset();
      #5;
      check("R1 rd_data", phy_rd_data, 32'h0010_0000);
      check("R1 upd_req", 32'(upd_req), 0);
      check("R1 rx_pwrdn", 32'(rx_pwrdn), 1);
      check("R9 idle odt", 32'(local_odt), 0);
      check("R10 hold", 32'(phy_hold_rst), 0);
   endtask

   task automatic t_shadow_only();
      wr_shadow(mk(1, 1, 2'b01, 2'b00, 2'b10, 5'd6));
      #5;
      check("R2 readback", phy_rd_data, mk(1, 1, 2'b01, 2'b00, 2'b10, 5'd6));
      check("R2 hold unchanged", 32'(phy_hold_rst), 0);
      check("R2 odt unchanged", 32'(local_odt), 0);
   endtask

   task automatic t_handshake();
      @(negedge clk); mcfg_wr_en = 1'b1;
      @(negedge clk); mcfg_wr_en = 1'b0; #5;
      check("R3 req set", 32'(upd_req), 1);
      repeat (3) @(negedge clk);
      #5;
      check("R3 req held", 32'(upd_req), 1);
      check("R3 not yet applied", 32'(phy_hold_rst), 0);
      @(negedge clk); upd_ack = 1'b1;
      @(negedge clk); upd_ack = 1'b0; #5;
      check("R3 req cleared", 32'(upd_req), 0);
      check("R10 hold applied", 32'(phy_hold_rst), 1);
      check("R9 idle odt 01", 32'(local_odt), 1);
   endtask

   task automatic t_window();
      int n;
      count_window(0, 4'd4, 4'd4, n);
      check("R5 lat6 bl4", 32'(n), 11);
      wr_shadow(mk(1, 1, 2'b01, 2'b11, 2'b10, 5'd9)); commit();
      count_window(0, 4'd2, 4'd2, n);
      check("R5 lat9 bl2", 32'(n), 12);
      check("R10 wr odt", 32'(wr_local_odt), 3);
      wr_shadow(mk(1, 1, 2'b01, 2'b00, 2'b10, 5'd6)); commit();
      count_window(3, 4'd4, 4'd4, n);
      check("R6 extend", 32'(n), 14);
      count_window(2, 4'd9, 4'd0, n);
      check("R6 shorter second", 32'(n), 16);
   endtask

   task automatic t_read_odt();
      @(negedge clk); rd_cmd = 1'b1; burst_len = 4'd4; #5;
      check("R8 read odt", 32'(local_odt), 2);
      @(negedge clk); rd_cmd = 1'b0; dq_oe = 1'b1; #5;
      check("R8 oe masks", 32'(local_odt), 0);
      check("R7 powered in read", 32'(rx_pwrdn), 0);
      @(negedge clk); dq_oe = 1'b0;
      repeat (20) @(negedge clk);
      #5;
      check("R9 idle after read", 32'(local_odt), 1);
   endtask

   task automatic t_static();
      int n;
      wr_shadow(mk(0, 0, 2'b01, 2'b00, 2'b11, 5'd6)); commit();
      #5;
      check("R7 static powered", 32'(rx_pwrdn), 0);
      check("R9 static odt 00", 32'(local_odt), 0);
      check("R10 hold released", 32'(phy_hold_rst), 0);
      @(negedge clk); rd_cmd = 1'b1; burst_len = 4'd1; #5;
      check("R8 static read odt", 32'(local_odt), 3);
      @(negedge clk); rd_cmd = 1'b0;
      count_window(0, 4'd1, 4'd1, n);
      check("R7 never down", 32'(n), 80);
   endtask

   task automatic t_stray_ack();
      wr_shadow(mk(1, 1, 2'b10, 2'b01, 2'b10, 5'd6));
      @(negedge clk); upd_ack = 1'b1;
      @(negedge clk); upd_ack = 1'b0; #5;
      check("R4 stray ack hold", 32'(phy_hold_rst), 0);
      check("R4 stray ack odt", 32'(local_odt), 0);
      check("R4 stray ack wr", 32'(wr_local_odt), 0);
      check("R4 no req", 32'(upd_req), 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_shadow_only();
            t_handshake();
            t_window();
            t_read_odt();
            t_static();
            t_stray_ack();
         end
         begin
            repeat (20000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule